// File: doc/BRIEF.md
# Per-Timeslot Channel Control Datapath

This block sits between the line side and the system side of a framed TDM link. It handles 24 byte timeslots per frame in T1 mode and 32 in E1 mode. It keeps one 8-bit control word for every timeslot. On each timeslot strobe it uses that slot's word to route three things:

- **Line-bound byte**: the system transmit byte, a loopback of the line-received byte, or a digital-milliwatt test byte.
- **System-bound byte**: the line-received byte, a loopback of the system transmit byte, or the milliwatt byte.
- **Transmit signaling**: taken either from the system-side signaling stream or from a processor-held register value.

The block also flags whether robbed-bit signaling is inhibited for the slot. It passes out the slot's inversion and message controls.

Control words are written through a simple write port into a shadow bank. The shadow bank is copied to the active bank when timeslot 0 of the next frame begins. Each frame therefore runs on one coherent set of words. The milliwatt sequencer steps through an eight-byte pattern, one byte per frame. The pattern depends on the mode.

Top module: `tsctl_channel_ctl`

## Requirements
- R1: The first slot strobe after reset, or any strobe with `frame_sync` high, is timeslot 0. Later strobes count up and wrap to 0 after timeslot 23 when `mode_e1`=0, or after timeslot 31 when `mode_e1`=1. The index of each processed slot appears on `out_slot`.
- R2: All data outputs load one clock after a cycle with `slot_tick` high and hold their value in every other cycle. `out_valid` is high only in the clock after a strobe.
- R3: Control bit 0 set drives `rbs_inhibit` high for that slot in T1 mode. In E1 mode `rbs_inhibit` stays 0 whatever bit 0 holds.
- R4: Control bit 1 set selects `cpu_sig_in` for `tx_sig`. Bit 1 clear selects `sys_sig_in`.
- R5: Control bit 4 set makes `sys_rx_data` equal the slot's `sys_tx_data` input. With bit 4 clear and no test insert, `sys_rx_data` equals `line_rx_data`.
- R6: Control bit 5 set makes `line_tx_data` equal the slot's `line_rx_data` input. With bit 5 clear and no test insert, `line_tx_data` equals `sys_tx_data`.
- R7: Bits 4 and 5 may both be set in the same slot, which swaps the two directions.
- R8: With `test_sel`=1 and control bit 3 set, `line_tx_data` carries the milliwatt byte. With `test_sel`=0, bit 3 has no effect.
- R9: With `test_sel`=1 and control bit 2 set, `sys_rx_data` carries the milliwatt byte. With `test_sel`=0, bit 2 has no effect.
- R10: The milliwatt byte for frame k after reset (k=0 first) is entry k mod 8 of a pattern list. In T1 the list is 1E,0B,0B,1E,9E,8B,8B,9E (hex). In E1 it is 34,21,21,34,B4,A1,A1,B4 (hex).
- R11: When a test-insert bit and a loopback bit select the same output, the milliwatt byte wins.
- R12: All control words are 0 after reset. A write takes effect from the next timeslot 0 onward. A write made mid-frame does not change the slots that remain in the current frame.
- R13: `ch_invert` follows control bit 6 in both modes. `ch_txmsg` follows bit 7 in T1 mode and is 0 in E1 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 0 = 24-slot T1 frame, 1 = 32-slot E1 frame |
| test_sel | input | 1 | 1 = milliwatt insertion enabled |
| slot_tick | input | 1 | One-cycle strobe per timeslot byte |
| frame_sync | input | 1 | With slot_tick, marks timeslot 0 |
| cfg_we | input | 1 | Control word write enable |
| cfg_addr | input | 5 | Timeslot index to write |
| cfg_wdata | input | 8 | Control word value |
| sys_tx_data | input | 8 | System-side transmit byte for the slot |
| line_rx_data | input | 8 | Line-received byte for the slot |
| sys_sig_in | input | 4 | Signaling bits from the system stream |
| cpu_sig_in | input | 4 | Signaling bits from the processor register |
| out_valid | output | 1 | Outputs refreshed this cycle |
| out_slot | output | 5 | Timeslot index of the outputs |
| line_tx_data | output | 8 | Byte sent to the line |
| sys_rx_data | output | 8 | Byte sent to the system side |
| tx_sig | output | 4 | Selected transmit signaling |
| rbs_inhibit | output | 1 | Robbed-bit signaling suppressed |
| ch_invert | output | 1 | Per-slot inversion control |
| ch_txmsg | output | 1 | Per-slot transmit message control (T1 only) |

## Verification
The bench rewrites a control word and then strobes a timeslot in the middle of a frame. A design that committed writes at once would switch the loopback too early. The bench runs frames that are only timeslot 0 so the milliwatt index steps through all eight entries and wraps, and it changes mode between those frames. An off-by-one phase would show the wrong byte in the first frame. The bench sets test and loopback bits together to catch a reversed priority. It sets bits 0 and 7 in E1 mode to catch mode gating that was left out. It also counts full T1 and E1 frames to catch a wrap point that is wrong by one slot.

// File: rtl/tsctl_pkg.sv
package tsctl_pkg;

   localparam int WORD_W = 8;

   // Control word layout; bit positions are decoded by the datapath mux
   typedef struct packed {
      logic txmsg;      // bit 7
      logic invert;     // bit 6
      logic line_loop;  // bit 5: line rx -> line tx
      logic sys_loop;   // bit 4: system tx -> system rx
      logic tx_test;    // bit 3
      logic rx_test;    // bit 2
      logic sig_cpu;    // bit 1
      logic clear_ch;   // bit 0
   } ctl_word_t;

   // Milliwatt byte: entries 0 and 3 of each half use the outer value,
   // entries 1 and 2 the inner one; the second half sets the sign bit.
   function automatic logic [WORD_W-1:0] mw_pattern(input logic e1, input logic [2:0] idx);
      logic       outer;
      logic [6:0] mag;
      outer = (idx[1:0] == 2'd0) || (idx[1:0] == 2'd3);
      if (e1) mag = outer ? 7'h34 : 7'h21;
      else    mag = outer ? 7'h1E : 7'h0B;
      return {idx[2], mag};
   endfunction

endpackage

// File: rtl/tsctl_slot_counter.sv
module tsctl_slot_counter #(
   parameter int MAX_SLOTS = 32,
   parameter int T1_SLOTS  = 24,
   localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_e1,
   input  logic              tick,
   input  logic              sync,
   output logic [SLOT_W-1:0] slot_now,
   output logic              first
);

   logic [SLOT_W-1:0] cnt;
   logic [SLOT_W-1:0] last;

   assign last     = mode_e1 ? SLOT_W'(MAX_SLOTS - 1) : SLOT_W'(T1_SLOTS - 1);
   assign slot_now = (sync || cnt >= last) ? '0 : cnt + SLOT_W'(1);
   assign first    = (slot_now == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= SLOT_W'(MAX_SLOTS - 1);
      else if (tick) cnt <= slot_now;
   end

   // R1
   sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sync) |=> (cnt == '0));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

endmodule

// File: rtl/tsctl_cfg_ram.sv
module tsctl_cfg_ram #(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              commit,
   input  logic [ADDR_W-1:0] rd_slot,
   input  logic              rd_first,
   output logic [WORD_W-1:0] rd_word
);

   logic [DEPTH-1:0][WORD_W-1:0] shadow;
   logic [DEPTH-1:0][WORD_W-1:0] active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
      end else begin
         if (commit) active <= shadow;
         for (int i = 0; i < DEPTH; i++) begin
            if (we && waddr == ADDR_W'(i)) shadow[i] <= wdata;
         end
      end
   end

   // Slot 0 of a new frame reads the bank being committed at this edge
   assign rd_word = rd_first ? shadow[0] : active[rd_slot];

   // R12
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active));

endmodule

// File: rtl/tsctl_mw_seq.sv
module tsctl_mw_seq #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              first,
   input  logic              mode_e1,
   output logic [WORD_W-1:0] mw_byte
);

   logic [2:0] ph;
   logic [2:0] idx;

   // ph holds the index of the frame in progress; it starts at 7 so frame 0 uses entry 0
   assign idx     = first ? ph + 3'd1 : ph;
   assign mw_byte = WORD_W'(tsctl_pkg::mw_pattern(mode_e1, idx));

   always_ff @(posedge clk) begin
      if (!rst_n)              ph <= 3'd7;
      else if (tick && first)  ph <= idx;
   end

   // R10
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && first) |=> $stable(ph));

endmodule

// File: rtl/tsctl_channel_ctl.sv
module tsctl_channel_ctl #(
   parameter int MAX_SLOTS = 32,
   parameter int T1_SLOTS  = 24,
   parameter int SIG_W     = 4,
   localparam int SLOT_W   = $clog2(MAX_SLOTS),
   localparam int WORD_W   = tsctl_pkg::WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_e1,
   input  logic              test_sel,
   input  logic              slot_tick,
   input  logic              frame_sync,
   input  logic              cfg_we,
   input  logic [SLOT_W-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic [WORD_W-1:0] sys_tx_data,
   input  logic [WORD_W-1:0] line_rx_data,
   input  logic [SIG_W-1:0]  sys_sig_in,
   input  logic [SIG_W-1:0]  cpu_sig_in,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [WORD_W-1:0] line_tx_data,
   output logic [WORD_W-1:0] sys_rx_data,
   output logic [SIG_W-1:0]  tx_sig,
   output logic              rbs_inhibit,
   output logic              ch_invert,
   output logic              ch_txmsg
);

   import tsctl_pkg::*;

   generate
      if (T1_SLOTS < 1 || T1_SLOTS > MAX_SLOTS) begin : g_bad_t1
         $error("T1_SLOTS must lie in 1..MAX_SLOTS");
      end
      if (MAX_SLOTS < 2) begin : g_bad_max
         $error("MAX_SLOTS must be at least 2");
      end
      if (SIG_W < 1) begin : g_bad_sig
         $error("SIG_W must be positive");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_now;
   logic              first;
   logic [WORD_W-1:0] word_raw;
   logic [WORD_W-1:0] mw_byte;
   ctl_word_t         w;

   tsctl_slot_counter #(.MAX_SLOTS(MAX_SLOTS), .T1_SLOTS(T1_SLOTS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .tick(slot_tick),
      .sync(frame_sync), .slot_now(slot_now), .first(first)
   );

   tsctl_cfg_ram #(.DEPTH(MAX_SLOTS), .WORD_W(WORD_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
      .commit(slot_tick && first), .rd_slot(slot_now), .rd_first(first),
      .rd_word(word_raw)
   );

   tsctl_mw_seq #(.WORD_W(WORD_W)) u_mw (
      .clk(clk), .rst_n(rst_n), .tick(slot_tick), .first(first),
      .mode_e1(mode_e1), .mw_byte(mw_byte)
   );

   assign w = ctl_word_t'(word_raw);

   logic [WORD_W-1:0] line_nxt, sys_nxt;

   always_comb begin
      if (test_sel && w.tx_test) line_nxt = mw_byte;
      else if (w.line_loop)      line_nxt = line_rx_data;
      else                       line_nxt = sys_tx_data;

      if (test_sel && w.rx_test) sys_nxt = mw_byte;
      else if (w.sys_loop)       sys_nxt = sys_tx_data;
      else                       sys_nxt = line_rx_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_slot     <= '0;
         line_tx_data <= '0;
         sys_rx_data  <= '0;
         tx_sig       <= '0;
         rbs_inhibit  <= 1'b0;
         ch_invert    <= 1'b0;
         ch_txmsg     <= 1'b0;
      end else begin
         out_valid <= slot_tick;
         if (slot_tick) begin
            out_slot     <= slot_now;
            line_tx_data <= line_nxt;
            sys_rx_data  <= sys_nxt;
            tx_sig       <= w.sig_cpu ? cpu_sig_in : sys_sig_in;
            rbs_inhibit  <= w.clear_ch && !mode_e1;
            ch_invert    <= w.invert;
            ch_txmsg     <= w.txmsg && !mode_e1;
         end
      end
   end

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> $stable({line_tx_data, sys_rx_data, tx_sig, out_slot}));

   // R3
   rbs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rbs_inhibit) |-> !$past(mode_e1));

   // R13
   txmsg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_txmsg) |-> !$past(mode_e1));

endmodule

// File: tb/tb_tsctl_channel_ctl.sv
module tb_tsctl_channel_ctl;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, mode_e1, test_sel, slot_tick, frame_sync, cfg_we;
   logic [4:0] cfg_addr;
   logic [7:0] cfg_wdata, sys_tx_data, line_rx_data;
   logic [3:0] sys_sig_in, cpu_sig_in;
   logic       out_valid;
   logic [4:0] out_slot;
   logic [7:0] line_tx_data, sys_rx_data;
   logic [3:0] tx_sig;
   logic       rbs_inhibit, ch_invert, ch_txmsg;

   tsctl_channel_ctl dut (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .test_sel(test_sel),
      .slot_tick(slot_tick), .frame_sync(frame_sync), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sys_tx_data(sys_tx_data),
      .line_rx_data(line_rx_data), .sys_sig_in(sys_sig_in), .cpu_sig_in(cpu_sig_in),
      .out_valid(out_valid), .out_slot(out_slot), .line_tx_data(line_tx_data),
      .sys_rx_data(sys_rx_data), .tx_sig(tx_sig), .rbs_inhibit(rbs_inhibit),
      .ch_invert(ch_invert), .ch_txmsg(ch_txmsg)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mw_exp(input logic e1, input int k);
      logic [7:0] t1 [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
      logic [7:0] eo [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
      return e1 ? eo[k % 8] : t1[k % 8];
   endfunction

   task automatic do_write(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_tick(input logic sync, input logic [7:0] stx, input logic [7:0] lrx);
      @(negedge clk);
      slot_tick = 1'b1; frame_sync = sync; sys_tx_data = stx; line_rx_data = lrx;
      @(negedge clk);
      slot_tick = 1'b0; frame_sync = 1'b0;
   endtask

   // {e1, test_sel, word[7:0], line source, sys source}; source 0=sys_tx 1=line_rx 2=milliwatt
   localparam logic [13:0] VEC [14] = '{
      {1'b0, 1'b0, 8'h00, 2'd0, 2'd1},  // R5 R6 plain routing
      {1'b0, 1'b0, 8'h10, 2'd0, 2'd0},  // R5 system loop
      {1'b0, 1'b0, 8'h20, 2'd1, 2'd1},  // R6 line loop
      {1'b0, 1'b0, 8'h30, 2'd1, 2'd0},  // R7 both loops
      {1'b0, 1'b1, 8'h08, 2'd2, 2'd1},  // R8
      {1'b0, 1'b1, 8'h04, 2'd0, 2'd2},  // R9
      {1'b0, 1'b1, 8'h3C, 2'd2, 2'd2},  // R11 test over loop
      {1'b0, 1'b0, 8'h0C, 2'd0, 2'd1},  // R8 R9 test bits ignored
      {1'b1, 1'b1, 8'h08, 2'd2, 2'd1},  // R10 E1 pattern, index wraps
      {1'b1, 1'b1, 8'h28, 2'd2, 2'd1},  // R11 E1
      {1'b1, 1'b0, 8'h30, 2'd1, 2'd0},  // R7 E1
      {1'b0, 1'b1, 8'h14, 2'd0, 2'd2},  // R9 R11
      {1'b0, 1'b0, 8'hC3, 2'd0, 2'd1},  // R3 R4 R13 T1
      {1'b1, 1'b0, 8'hC3, 2'd0, 2'd1}   // R3 R13 E1 gating
   };

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode_e1 = 1'b0; test_sel = 1'b0; slot_tick = 1'b0; frame_sync = 1'b0;
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; sys_tx_data = '0; line_rx_data = '0;
      sys_sig_in = 4'h5; cpu_sig_in = 4'hA;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 reset valid", out_valid, 0);
      chk("R2 reset line", line_tx_data, 0);
      chk("R2 reset sys", sys_rx_data, 0);

      // Table: one-slot frames, so each row is a new frame k = row index
      for (int i = 0; i < 14; i++) begin
         logic [13:0] v;
         logic [7:0]  wd, stx, lrx, el, es;
         v = VEC[i];
         wd = v[11:4];
         stx = 8'h40 + 8'(i);
         lrx = 8'h60 + 8'(i);
         do_write(5'd0, wd);
         mode_e1 = v[13]; test_sel = v[12];
         do_tick(1'b1, stx, lrx);
         el = (v[3:2] == 2'd0) ? stx : (v[3:2] == 2'd1) ? lrx : mw_exp(v[13], i);
         es = (v[1:0] == 2'd0) ? stx : (v[1:0] == 2'd1) ? lrx : mw_exp(v[13], i);
         chk($sformatf("R6 R8 R10 R11 line row %0d", i), line_tx_data, el);
         chk($sformatf("R5 R9 R10 R11 sys row %0d", i), sys_rx_data, es);
         chk($sformatf("R4 sig row %0d", i), tx_sig, wd[1] ? 4'hA : 4'h5);
         chk($sformatf("R3 rbs row %0d", i), rbs_inhibit, wd[0] & ~v[13]);
         chk($sformatf("R13 inv row %0d", i), ch_invert, wd[6]);
         chk($sformatf("R13 msg row %0d", i), ch_txmsg, wd[7] & ~v[13]);
      end
      chk("R2 valid after strobe", out_valid, 1);

      // R1 T1 wrap
      test_sel = 1'b0; mode_e1 = 1'b0;
      do_tick(1'b1, 8'h00, 8'h00);
      chk("R1 sync slot", out_slot, 0);
      repeat (23) do_tick(1'b0, 8'h00, 8'h00);
      chk("R1 T1 last slot", out_slot, 23);
      do_tick(1'b0, 8'h00, 8'h00);
      chk("R1 T1 wrap", out_slot, 0);

      // R1 E1 wrap
      mode_e1 = 1'b1;
      do_tick(1'b1, 8'h00, 8'h00);
      repeat (31) do_tick(1'b0, 8'h00, 8'h00);
      chk("R1 E1 last slot", out_slot, 31);
      do_tick(1'b0, 8'h00, 8'h00);
      chk("R1 E1 wrap", out_slot, 0);

      // R12 mid-frame write waits for the next frame
      do_tick(1'b1, 8'h00, 8'h00);
      repeat (4) do_tick(1'b0, 8'h00, 8'h00);
      do_write(5'd5, 8'h10);
      do_tick(1'b0, 8'hA5, 8'h5A);
      chk("R12 old word kept mid-frame", sys_rx_data, 8'h5A);
      repeat (26) do_tick(1'b0, 8'h00, 8'h00);
      repeat (5) do_tick(1'b0, 8'h00, 8'h00);
      do_tick(1'b0, 8'hA5, 8'h5A);
      chk("R1 slot 5 next frame", out_slot, 5);
      chk("R12 new word next frame", sys_rx_data, 8'hA5);

      // R2 hold between strobes
      sys_tx_data = 8'h11; line_rx_data = 8'h22;
      repeat (3) @(negedge clk);
      chk("R2 hold sys", sys_rx_data, 8'hA5);
      chk("R2 hold line", line_tx_data, 8'hA5);
      chk("R2 valid low", out_valid, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule